// File: doc/BRIEF.md
# Multiply-Accumulate Slice with Operand Selection

This block is a pipelined 48-bit arithmetic slice. It forms the signed product of a 25-bit operand and an 18-bit operand. Three 48-bit selectors then choose the terms for a three-input adder/subtracter. A 7-bit selection word can change on every cycle. It picks the product, the fed-back result, a wide C operand, the concatenated A and B operands, a constant of all ones, a cascade input from a neighbouring slice, or copies of the result or the cascade input shifted right by 17 bits. The shifted copies let several slices be chained into multiplies wider than one slice.

The result is held in an output register. That register feeds the selectors on the next cycle, which makes accumulation possible. The register is also driven out on a cascade output for the next slice. Along with the result the block reports a carry per 12-bit section of the final add, an equality flag against a fixed pattern, and an error flag. The error flag marks a selection code that has no defined meaning. For such a code the result is held.

Top module: `mac_slice`

## Requirements
- R1: With the selection word `opmode` = 7'b000_01_01, P becomes the signed product of A (25-bit) and B (18-bit), sign-extended to 48 bits, plus `cin`.
- R2: Bits [1:0] of `opmode` choose the X term: 00 gives zero, 01 gives the product, 10 gives P, and 11 gives {A sign-extended to 30 bits, B}.
- R3: Bits [3:2] choose the Y term: 00 gives zero, 10 gives 48'hFFFFFFFFFFFF, and 11 gives C. Code 01 is the product's second half and carries no value of its own.
- R4: Bits [6:4] choose the Z term: 000 gives zero, 001 gives PCIN, 010 gives P, and 011 gives C. Code 101 gives PCIN arithmetically shifted right by 17, and 110 gives P shifted the same way. Code 100 gives P and is legal only when bits [3:0] are 1000.
- R5: `alumode` 4'b0000 sets P = X + Y + cin + Z. `alumode` 4'b0011 sets P = X + Y + cin − Z. Both are taken modulo 2^48.
- R6: An illegal selection raises `op_err` on the cycle its result would appear, and leaves P and `cout` unchanged. The illegal selections are: Z code 111; exactly one of X and Y at code 01; Z code 100 with bits [3:0] not equal to 1000; and any `alumode` other than 0000 or 0011. The next legal selection clears `op_err` and builds on the held P.
- R7: Let T = (X + Y + cin) mod 2^48. The final add is T + Z, or T + ~Z + 1 when subtracting. `cout[i]` is the carry out of bit 12i+11 of that add. Bit 3 has no defined meaning while the product is selected.
- R8: `pat_hit` is high exactly while P equals the parameter `PAT_VALUE`.
- R9: With the default parameters, a result appears after the second rising edge that follows the inputs. A, B, the C/PCIN pair and the control word (`opmode`, `alumode`, `cin`) each pass through one register stage. `A_STAGES` and `B_STAGES` may be 0 to 2, and `CTRL_REG` may be 0 or 1.
- R10: While `ce` is low, no register changes, so P, `cout` and `op_err` hold.
- R11: A synchronous active-high `rst` clears P, `cout`, `op_err` and every pipeline stage.
- R12: `pcout` always equals P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every register |
| a_in | input | 25 | Signed multiplicand A |
| b_in | input | 18 | Signed multiplier B |
| c_in | input | 48 | Wide operand C |
| pcin | input | 48 | Cascade input from the previous slice |
| cin | input | 1 | Carry-in added to X and Y |
| opmode | input | 7 | Selection word: Z in [6:4], Y in [3:2], X in [1:0] |
| alumode | input | 4 | 0000 adds Z, 0011 subtracts Z |
| p_out | output | 48 | Registered result P |
| pcout | output | 48 | Cascade output, equal to P |
| cout | output | 4 | Carry out of each 12-bit section |
| pat_hit | output | 1 | P equals PAT_VALUE |
| op_err | output | 1 | Last selection was illegal; P was held |

## Verification
Result feedback and illegal-selection holding can act in the same cycle. An illegal code can arrive straight after an accumulation that reads P back, and the legal accumulation that follows must then build on the held value, not on a value the illegal code would have produced. The bench provokes this by running back-to-back streams of P-feedback, illegal and accumulate selections, one per clock. Its queue model carries its own copy of P, and that copy moves forward only on legal selections. Pattern equality is judged in the same stream: the flag must rise when an accumulation lands exactly on the pattern value and fall on the next step away from it.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int AW    = 25;  // multiplicand width
  localparam int BW    = 18;  // multiplier width
  localparam int DW    = 48;  // datapath width
  localparam int SW    = 12;  // carry section width
  localparam int SHIFT = 17;  // cascade shift distance

  typedef struct packed {
    logic [2:0] z;
    logic [1:0] y;
    logic [1:0] x;
  } opmode_t;

  // signed product, sign-extended to the datapath width
  function automatic logic [DW-1:0] f_product(input logic [AW-1:0] a, input logic [BW-1:0] b);
    logic signed [DW-1:0] sa, sb;
    sa = DW'($signed(a));
    sb = DW'($signed(b));
    return sa * sb;
  endfunction

  // arithmetic right shift used for wide-multiply chaining
  function automatic logic [DW-1:0] f_shr(input logic [DW-1:0] v);
    logic signed [DW-1:0] s;
    s = v;
    return s >>> SHIFT;
  endfunction

  // A sign-extended above B to fill the datapath
  function automatic logic [DW-1:0] f_abcat(input logic [AW-1:0] a, input logic [BW-1:0] b);
    return {{(DW-AW-BW){a[AW-1]}}, a, b};
  endfunction
endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (N == 0) begin : g_wire
    assign q = d;
  end else begin : g_regs
    logic [W-1:0] r [N];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < N; i++) r[i] <= '0;
      end else if (ce) begin
        r[0] <= d;
        for (int i = 1; i < N; i++) r[i] <= r[i-1];
      end
    end
    assign q = r[N-1];
  end
endmodule

// File: rtl/mac_opsel.sv
module mac_opsel import mac_pkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  opmode_t       op,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic [DW-1:0] pcin,
  input  logic [DW-1:0] p,
  output logic [DW-1:0] x,
  output logic [DW-1:0] y,
  output logic [DW-1:0] z,
  output logic          illegal
);
  logic [DW-1:0] prod;
  logic          mult_x, mult_y;

  assign prod   = f_product(a, b);
  assign mult_x = (op.x == 2'b01);
  assign mult_y = (op.y == 2'b01);

  always_comb begin
    case (op.x)
      2'b00:   x = '0;
      2'b01:   x = prod;            // whole product rides on X
      2'b10:   x = p;
      default: x = f_abcat(a, b);
    endcase
    case (op.y)
      2'b10:   y = '1;
      2'b11:   y = c;
      default: y = '0;              // 01: companion half of the product
    endcase
    case (op.z)
      3'b001:        z = pcin;
      3'b010, 3'b100: z = p;
      3'b011:        z = c;
      3'b101:        z = f_shr(pcin);
      3'b110:        z = f_shr(p);
      default:       z = '0;
    endcase
  end

  assign illegal = (op.z == 3'b111) | (mult_x ^ mult_y) |
                   ((op.z == 3'b100) && ({op.y, op.x} != 4'b1000));

  p_zcode7_r6: assert property (@(posedge clk) disable iff (rst)
    (op.z == 3'b111) |-> illegal);
  p_lonely_mult_r6: assert property (@(posedge clk) disable iff (rst)
    ((op.x == 2'b01) != (op.y == 2'b01)) |-> illegal);
  p_z4_macc_r4: assert property (@(posedge clk) disable iff (rst)
    (op.z == 3'b100 && !illegal) |-> (op.y == 2'b10 && op.x == 2'b00));
endmodule

// File: rtl/mac_addsec.sv
module mac_addsec import mac_pkg::*; (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] z,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic [DW/SW-1:0] cout
);
  localparam int NSEC = DW / SW;

  logic [DW-1:0] t, zop;
  logic [NSEC:0] cc;

  assign t     = x + y + DW'(cin);
  assign zop   = sub ? ~z : z;
  assign cc[0] = sub;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign {cc[s+1], sum[s*SW +: SW]} =
      {1'b0, t[s*SW +: SW]} + {1'b0, zop[s*SW +: SW]} + (SW+1)'(cc[s]);
  end

  assign cout = cc[NSEC:1];
endmodule

// File: rtl/mac_slice.sv
module mac_slice import mac_pkg::*; #(
  parameter int          A_STAGES  = 1,
  parameter int          B_STAGES  = 1,
  parameter int          CTRL_REG  = 1,
  parameter logic [47:0] PAT_VALUE = 48'h0000_0000_1234
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ce,
  input  logic [24:0] a_in,
  input  logic [17:0] b_in,
  input  logic [47:0] c_in,
  input  logic [47:0] pcin,
  input  logic        cin,
  input  logic [6:0]  opmode,
  input  logic [3:0]  alumode,
  output logic [47:0] p_out,
  output logic [47:0] pcout,
  output logic [3:0]  cout,
  output logic        pat_hit,
  output logic        op_err
);
  localparam int NSEC = DW / SW;
  localparam int CW   = 7 + 4 + 1;

  logic [AW-1:0]   a_q;
  logic [BW-1:0]   b_q;
  logic [2*DW-1:0] cp_q;
  logic [CW-1:0]   ctrl_q;
  opmode_t         op_q;
  logic [3:0]      alu_q;
  logic            cin_q;
  logic [DW-1:0]   xv, yv, zv, sum;
  logic [NSEC-1:0] cy;
  logic            sel_bad, alu_bad, bad, sub;
  logic [DW-1:0]   p_q;
  logic [NSEC-1:0] cout_q;
  logic            err_q;

  mac_stage #(.W(AW),   .N(A_STAGES)) u_a    (.clk, .rst, .ce, .d(a_in), .q(a_q));
  mac_stage #(.W(BW),   .N(B_STAGES)) u_b    (.clk, .rst, .ce, .d(b_in), .q(b_q));
  mac_stage #(.W(2*DW), .N(1))        u_cp   (.clk, .rst, .ce, .d({c_in, pcin}), .q(cp_q));
  mac_stage #(.W(CW),   .N(CTRL_REG)) u_ctrl (.clk, .rst, .ce,
                                              .d({opmode, alumode, cin}), .q(ctrl_q));

  assign op_q  = opmode_t'(ctrl_q[CW-1:5]);
  assign alu_q = ctrl_q[4:1];
  assign cin_q = ctrl_q[0];

  mac_opsel u_sel (
    .clk, .rst, .op(op_q), .a(a_q), .b(b_q),
    .c(cp_q[2*DW-1:DW]), .pcin(cp_q[DW-1:0]), .p(p_q),
    .x(xv), .y(yv), .z(zv), .illegal(sel_bad)
  );

  assign sub     = (alu_q == 4'b0011);
  assign alu_bad = !((alu_q == 4'b0000) || sub);
  assign bad     = sel_bad | alu_bad;

  mac_addsec u_add (.x(xv), .y(yv), .z(zv), .cin(cin_q), .sub(sub), .sum(sum), .cout(cy));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q    <= '0;
      cout_q <= '0;
      err_q  <= 1'b0;
    end else if (ce) begin
      err_q <= bad;
      if (!bad) begin
        p_q    <= sum;
        cout_q <= cy;
      end
    end
  end

  assign p_out   = p_q;
  assign pcout   = p_q;
  assign cout    = cout_q;
  assign op_err  = err_q;
  assign pat_hit = (p_q == PAT_VALUE);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (p_out == '0 && cout == '0 && !op_err));
  p_ce_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(p_out) && $stable(cout) && $stable(op_err)));
  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && bad) |=> ($stable(p_out) && $stable(cout) && op_err));
endmodule

// File: tb/tb_mac_slice.sv
module tb_mac_slice;
  localparam int          CLK_PERIOD = 10;
  localparam logic [47:0] PAT        = 48'h0000_0000_1234;
  localparam logic [6:0]  MUL        = 7'b000_01_01;
  localparam logic [3:0]  ADD = 4'b0000, SUB = 4'b0011;

  logic        clk = 1'b0, rst = 1'b1, ce = 1'b1;
  logic [24:0] a_in = '0;
  logic [17:0] b_in = '0;
  logic [47:0] c_in = '0, pcin = '0;
  logic        cin = 1'b0;
  logic [6:0]  opmode = '0;
  logic [3:0]  alumode = '0;
  logic [47:0] p_out, pcout;
  logic [3:0]  cout;
  logic        pat_hit, op_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_slice #(.PAT_VALUE(PAT)) dut (
    .clk, .rst, .ce, .a_in, .b_in, .c_in, .pcin, .cin, .opmode, .alumode,
    .p_out, .pcout, .cout, .pat_hit, .op_err
  );

  typedef struct {
    logic [47:0] p;
    logic        err;
    logic [3:0]  cy;
    logic        mul;
    int          due;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_tests = 0, n_fail = 0, cyc = 0;
  bit          done = 0;
  logic [47:0] m_p = '0;
  logic [3:0]  m_c = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: present one input set and push the result the requirements predict
  task automatic drive(input logic [24:0] a, input logic [17:0] b, input logic [47:0] c,
                       input logic [47:0] pc, input logic ci, input logic [6:0] op,
                       input logic [3:0] alu, input string tag);
    logic [47:0] xv, yv, zv, t, zo;
    logic [48:0] part, mk;
    logic        bad, mul, sb;
    longint      pa, pb;
    exp_t        e;
    @(negedge clk);
    a_in = a; b_in = b; c_in = c; pcin = pc; cin = ci; opmode = op; alumode = alu;
    mul = (op[1:0] == 2'b01) && (op[3:2] == 2'b01);
    bad = (op[6:4] == 3'd7) || ((op[1:0] == 2'b01) != (op[3:2] == 2'b01)) ||
          (op[6:4] == 3'd4 && op[3:0] != 4'b1000) || !(alu == ADD || alu == SUB);
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    if (mul) begin
      xv = 48'(pa * pb);
      yv = '0;
    end else begin
      case (op[1:0])
        2'b10:   xv = m_p;
        2'b11:   xv = {{5{a[24]}}, a, b};
        default: xv = '0;
      endcase
      case (op[3:2])
        2'b10:   yv = 48'hFFFF_FFFF_FFFF;
        2'b11:   yv = c;
        default: yv = '0;
      endcase
    end
    case (op[6:4])
      3'd1:       zv = pc;
      3'd2, 3'd4: zv = m_p;
      3'd3:       zv = c;
      3'd5:       zv = {{17{pc[47]}}, pc[47:17]};
      3'd6:       zv = {{17{m_p[47]}}, m_p[47:17]};
      default:    zv = '0;
    endcase
    sb = (alu == SUB);
    t  = xv + yv + 48'(ci);
    zo = sb ? ~zv : zv;
    if (!bad) begin
      m_p = t + zo + 48'(sb);
      for (int i = 0; i < 4; i++) begin
        mk   = (49'd1 << (12*i + 12)) - 49'd1;
        part = ({1'b0, t} & mk) + ({1'b0, zo} & mk) + 49'(sb);
        m_c[i] = part[12*i + 12];
      end
    end
    e.p = m_p; e.err = bad; e.cy = m_c; e.mul = mul; e.due = cyc + 2; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pop and compare as results land
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic [3:0] msk;
      e = q.pop_front();
      msk = e.mul ? 4'b0111 : 4'b1111;
      check({e.tag, " P"}, p_out, e.p);
      check("R12 pcout", pcout, e.p);
      check("R6 op_err", 48'(op_err), 48'(e.err));
      check("R7 cout", 48'(cout & msk), 48'(e.cy & msk));
      check("R8 pat_hit", 48'(pat_hit), 48'(e.p == PAT));
    end
  end

  initial begin
    logic [47:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset P", p_out, '0);
    check("R11 reset err", 48'(op_err), '0);
    check("R11 reset cout", 48'(cout), '0);

    drive(25'd3, 18'd5, '0, '0, 1'b0, MUL, ADD, "R1 R9 small product");
    drive(25'h1FFFFF9, 18'd1000, '0, '0, 1'b0, MUL, ADD, "R1 negative");
    drive(25'h1000000, 18'h20000, '0, '0, 1'b1, MUL, ADD, "R1 min*min+cin");
    drive(25'h0FFFFFF, 18'h3FFFF, '0, '0, 1'b0, MUL, ADD, "R1 max*-1");
    drive(25'h1FFFFFE, 18'h00ABC, '0, '0, 1'b0, 7'b000_00_11, ADD, "R2 A:B");
    drive('0, '0, 48'd100, '0, 1'b0, 7'b000_11_10, ADD, "R2 R3 P+C");
    drive('0, '0, 48'h10, '0, 1'b0, 7'b011_10_00, ADD, "R3 ones+C");
    drive('0, '0, 48'd5, 48'h1000, 1'b0, 7'b001_11_00, ADD, "R4 PCIN");
    drive('0, '0, '0, 48'h8000_0000_0000, 1'b0, 7'b101_00_00, ADD, "R4 PCIN>>17");
    drive('0, '0, 48'd1, '0, 1'b0, 7'b110_11_00, ADD, "R4 P>>17");
    drive('0, '0, '0, '0, 1'b0, 7'b100_10_00, ADD, "R4 MACC extend");
    drive('0, 18'd9, '0, '0, 1'b0, 7'b010_00_11, ADD, "R4 P+A:B");
    drive('0, 18'h00010, 48'h20, '0, 1'b0, 7'b011_00_11, SUB, "R5 A:B-C");
    drive(25'd10, 18'd10, 48'd300, '0, 1'b0, 7'b011_01_01, SUB, "R5 prod-C");
    drive('0, 18'h00FFF, 48'd1, '0, 1'b0, 7'b011_00_11, ADD, "R7 section0 carry");
    drive(25'h1FFFFFF, 18'h3FFFF, 48'd1, '0, 1'b0, 7'b011_00_11, ADD, "R7 full ripple");
    drive('0, '0, 48'd3, '0, 1'b0, 7'b000_11_10, ADD, "R6 feed before illegal");
    drive('0, '0, '0, '0, 1'b0, 7'b111_00_00, ADD, "R6 z code 7");
    drive(25'd2, 18'd2, '0, '0, 1'b0, 7'b000_00_01, ADD, "R6 lone X mult");
    drive('0, '0, '0, '0, 1'b0, 7'b100_00_00, ADD, "R6 bad z4");
    drive('0, '0, 48'd4, '0, 1'b0, 7'b011_00_00, 4'b0001, "R6 bad alumode");
    drive('0, '0, 48'd7, '0, 1'b0, 7'b010_11_00, ADD, "R6 resume on held P");
    drive('0, 18'h01234, '0, '0, 1'b0, 7'b000_00_11, ADD, "R8 hit");
    drive('0, '0, '0, '0, 1'b0, 7'b010_11_00, ADD, "R8 stay");
    drive('0, '0, 48'd1, '0, 1'b0, 7'b010_11_00, ADD, "R8 leave");
    drive('0, '0, '0, '0, 1'b0, 7'b000_00_00, ADD, "R9 idle");
    wait (q.size() == 0);

    // R10: clock enable freeze, then resume
    @(negedge clk);
    rst = 1'b1; c_in = 48'd5; opmode = 7'b010_11_00; alumode = ADD;
    repeat (2) @(negedge clk);
    check("R11 reset mid-run", p_out, '0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    ce = 1'b0;
    snap = p_out;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 ce low hold", p_out, snap);
    end
    ce = 1'b1;
    @(negedge clk);
    check("R10 resume", p_out, snap + 48'd5);

    // R11: reset clears the running value
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset P", p_out, '0);
    check("R11 reset cout", 48'(cout), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule